// File: doc/BRIEF.md
# Set/Clear Control Flag Register Bank

This block holds the five control flags that steer a serial bus protocol engine: acknowledge enable, interrupt pending, stop request, start request and interface enable. Software never writes the control word as a whole. It reaches the flags through two bus addresses. A write to the set address turns on every flag whose data bit is one. A write to the clear address turns off every flag whose data bit is one. In both cases a zero data bit leaves its flag as it was, so one flag can change without a read-modify-write.

The protocol engine drives two pairs of hardware strobes. One pair sets and clears the interrupt flag. The other pair sets and clears the stop flag. A set always beats a clear in the same cycle, so an interrupt raised by hardware cannot be lost to a software clear issued at the same moment. Every flag is driven out as its own output pin. The current flags can also be read back at the set address.

Top module: `ctl_setclr_bank`

## Requirements
- R1: A synchronous active-high reset clears all five flags. While reset is held the flag outputs and the read data are zero.
- R2: A write to the set address (byte offset 0x00) turns on each flag whose data bit is one. Acknowledge enable is bit 2, stop request is bit 4, start request is bit 5 and interface enable is bit 6. A zero bit leaves its flag unchanged. The change shows on the outputs after the next rising clock edge.
- R3: A write to the clear address (byte offset 0x18) turns off each flag whose data bit is one. Acknowledge enable is bit 2, interrupt is bit 3, start is bit 5 and interface enable is bit 6. Clearing bit 6 disables the interface. A zero bit leaves its flag unchanged.
- R4: Bit 4 at the clear address has no effect. The stop flag keeps its value.
- R5: Bit 3 at the set address has no effect. Software cannot raise the interrupt flag.
- R6: A hardware set strobe turns its flag on after the next edge, and a hardware clear strobe turns it off. This holds for the interrupt flag and for the stop flag.
- R7: When a set and a clear of the same flag fall in the same cycle, the flag ends up on. This covers a hardware set against a software clear, and a hardware set against a hardware clear.
- R8: Read data at the set address returns the flags in bits 6:2, and bits 1:0 and 31:7 read as zero. Read data at any other address, including the write-only clear address, is zero.
- R9: A write to any address other than the set and clear addresses leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| hw_irq_set | input | 1 | Protocol engine raises the interrupt flag |
| hw_irq_clr | input | 1 | Protocol engine drops the interrupt flag |
| hw_stop_set | input | 1 | Protocol engine raises the stop request |
| hw_stop_clr | input | 1 | Protocol engine drops the stop request once the stop condition has gone out |
| ack_en | output | 1 | Acknowledge enable flag |
| irq_flag | output | 1 | Interrupt pending flag |
| stop_req | output | 1 | Stop request flag |
| start_req | output | 1 | Start request flag |
| if_en | output | 1 | Interface enable flag |

## Verification
The assertions assume that each strobe and each write lasts exactly one cycle and is sampled at the rising edge. They also assume that a write lands on one address at a time, so one cycle never carries a set write and a clear write together. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It writes only through the single shared address bus. Reserved data bits and unmapped addresses are driven on purpose, because their lack of effect is itself a requirement. The hardware strobes are sometimes raised together with each other and with software writes, so that the set-over-clear priority gets exercised.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    // Bus geometry
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    // Flag field inside the data word
    localparam int NFLAG    = 5;
    localparam int FLAG_LSB = 2;

    // Flag indices inside the field (bit = FLAG_LSB + index)
    localparam int IX_ACK   = 0;
    localparam int IX_IRQ   = 1;
    localparam int IX_STOP  = 2;
    localparam int IX_START = 3;
    localparam int IX_EN    = 4;

    // Which agent may set or clear each flag
    localparam logic [NFLAG-1:0] SW_SET_OK = 5'b11101; // no software raise of irq
    localparam logic [NFLAG-1:0] SW_CLR_OK = 5'b11011; // no software drop of stop
    localparam logic [NFLAG-1:0] HW_SET_OK = 5'b00110; // irq, stop
    localparam logic [NFLAG-1:0] HW_CLR_OK = 5'b00110; // irq, stop

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic en;
        logic start;
        logic stop;
        logic irq;
        logic ack;
    } ctl_flags_t;

    // Place the flag field into a full data word, reserved bits zero
    function automatic logic [DATA_W-1:0] flags_to_word(input flag_vec_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FLAG_LSB +: NFLAG] = f;
        return w;
    endfunction

    // Mask of the flag field within a data word
    function automatic logic [DATA_W-1:0] field_mask();
        return flags_to_word('1);
    endfunction

endpackage

// File: rtl/ctl_bus_decode.sv
module ctl_bus_decode
    import ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SET_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  flag_vec_t         wfield,
    output flag_vec_t         sw_set,
    output flag_vec_t         sw_clr,
    output logic              rd_sel
);

    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_set = (addr == SET_ADDR);
        hit_clr = (addr == CLR_ADDR);
        sw_set  = (wr && hit_set) ? wfield : '0;
        sw_clr  = (wr && hit_clr) ? wfield : '0;
        rd_sel  = hit_set;
    end

endmodule

// File: rtl/ctl_flag_cell.sv
module ctl_flag_cell #(
    parameter bit SW_SET_EN = 1'b1,
    parameter bit SW_CLR_EN = 1'b1,
    parameter bit HW_SET_EN = 1'b0,
    parameter bit HW_CLR_EN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    input  logic hw_clr,
    output logic q
);

    logic sw_set_g, sw_clr_g, hw_set_g, hw_clr_g;
    logic set_any, clr_any;

    generate
        if (SW_SET_EN) begin : g_sws
            assign sw_set_g = sw_set;
        end else begin : g_sws_off
            assign sw_set_g = 1'b0;
        end
        if (SW_CLR_EN) begin : g_swc
            assign sw_clr_g = sw_clr;
        end else begin : g_swc_off
            assign sw_clr_g = 1'b0;
        end
        if (HW_SET_EN) begin : g_hws
            assign hw_set_g = hw_set;
        end else begin : g_hws_off
            assign hw_set_g = 1'b0;
        end
        if (HW_CLR_EN) begin : g_hwc
            assign hw_clr_g = hw_clr;
        end else begin : g_hwc_off
            assign hw_clr_g = 1'b0;
        end
    endgenerate

    assign set_any = sw_set_g | hw_set_g;
    assign clr_any = sw_clr_g | hw_clr_g;

    // Set has priority over clear (R7)
    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (set_any) q <= 1'b1;
        else if (clr_any) q <= 1'b0;
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_any && clr_any) |=> q);

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_any && !set_any) |=> !q);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!set_any && !clr_any) |=> $stable(q));

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux
    import ctl_pkg::*;
(
    input  flag_vec_t         flags,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = rd_sel ? flags_to_word(flags) : '0;
    end

endmodule

// File: rtl/ctl_setclr_bank.sv
module ctl_setclr_bank
    import ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SET_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hw_irq_set,
    input  logic              hw_irq_clr,
    input  logic              hw_stop_set,
    input  logic              hw_stop_clr,
    output logic              ack_en,
    output logic              irq_flag,
    output logic              stop_req,
    output logic              start_req,
    output logic              if_en
);

    flag_vec_t  sw_set, sw_clr, hw_set, hw_clr, flags;
    logic       rd_sel;
    ctl_flags_t fl;

    ctl_bus_decode #(.SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wfield (bus_wdata[FLAG_LSB +: NFLAG]),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .rd_sel (rd_sel)
    );

    always_comb begin
        hw_set          = '0;
        hw_clr          = '0;
        hw_set[IX_IRQ]  = hw_irq_set;
        hw_clr[IX_IRQ]  = hw_irq_clr;
        hw_set[IX_STOP] = hw_stop_set;
        hw_clr[IX_STOP] = hw_stop_clr;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        ctl_flag_cell #(
            .SW_SET_EN (SW_SET_OK[i]),
            .SW_CLR_EN (SW_CLR_OK[i]),
            .HW_SET_EN (HW_SET_OK[i]),
            .HW_CLR_EN (HW_CLR_OK[i])
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .sw_set (sw_set[i]),
            .sw_clr (sw_clr[i]),
            .hw_set (hw_set[i]),
            .hw_clr (hw_clr[i]),
            .q      (flags[i])
        );
    end

    ctl_read_mux u_rd (
        .flags  (flags),
        .rd_sel (rd_sel),
        .rdata  (bus_rdata)
    );

    assign fl        = ctl_flags_t'(flags);
    assign ack_en    = fl.ack;
    assign irq_flag  = fl.irq;
    assign stop_req  = fl.stop;
    assign start_req = fl.start;
    assign if_en     = fl.en;

    // R5: interrupt only rises through the hardware strobe
    a_r5_irq_hw_only: assert property (@(posedge clk) disable iff (rst)
        !hw_irq_set |=> !$rose(irq_flag));

    // R4: stop unaffected by the clear address
    a_r4_stop_no_sw_clr: assert property (@(posedge clk) disable iff (rst)
        (!hw_stop_set && !hw_stop_clr &&
         !(bus_wr && bus_addr == SET_ADDR && bus_wdata[FLAG_LSB + IX_STOP]))
        |=> $stable(stop_req));

    // R8: reserved read bits are zero
    a_r8_rsvd_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~field_mask()) == '0);

    // R9: writes whose flag field is all zero change nothing
    a_r9_empty_write_holds: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_wdata & field_mask()) == '0 &&
         !hw_irq_set && !hw_irq_clr && !hw_stop_set && !hw_stop_clr)
        |=> $stable({ack_en, irq_flag, stop_req, start_req, if_en}));

    // R1: flags cleared after reset
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> ({ack_en, irq_flag, stop_req, start_req, if_en} == 5'b0));

endmodule

// File: tb/tb_ctl_setclr_bank.sv
`timescale 1ns/1ps
module tb_ctl_setclr_bank;

    localparam logic [7:0] A_SET = 8'h00;
    localparam logic [7:0] A_CLR = 8'h18;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        hw_irq_set, hw_irq_clr, hw_stop_set, hw_stop_clr;
    logic        ack_en, irq_flag, stop_req, start_req, if_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    bit m_ack, m_irq, m_stop, m_start, m_en;

    always #2 clk = ~clk; // 250 MHz

    ctl_setclr_bank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_irq_set(hw_irq_set), .hw_irq_clr(hw_irq_clr),
        .hw_stop_set(hw_stop_set), .hw_stop_clr(hw_stop_clr),
        .ack_en(ack_en), .irq_flag(irq_flag), .stop_req(stop_req),
        .start_req(start_req), .if_en(if_en)
    );

    task automatic compare(input string tag);
        logic [31:0] exp_rd;
        logic [4:0]  exp_fl, act_fl;
        exp_fl = {m_en, m_start, m_stop, m_irq, m_ack};
        act_fl = {if_en, start_req, stop_req, irq_flag, ack_en};
        exp_rd = 32'h0;
        if (!rst && bus_addr == A_SET) begin
            exp_rd[2] = m_ack; exp_rd[3] = m_irq; exp_rd[4] = m_stop;
            exp_rd[5] = m_start; exp_rd[6] = m_en;
        end
        checks++;
        if (act_fl !== exp_fl || bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s: flags=%b rdata=%h expected flags=%b rdata=%h",
                     tag, act_fl, bus_rdata, exp_fl, exp_rd);
        end
    endtask

    // One cycle: drive at falling edge, update model, compare after edge
    task automatic step(input string tag, input bit r, input logic [7:0] a,
                        input bit w, input logic [31:0] d,
                        input bit is, input bit ic, input bit ss, input bit sc);
        bit sset, sclr;
        rst = r; bus_addr = a; bus_wr = w; bus_wdata = d;
        hw_irq_set = is; hw_irq_clr = ic; hw_stop_set = ss; hw_stop_clr = sc;
        sset = w && (a == A_SET);
        sclr = w && (a == A_CLR);
        @(posedge clk);
        if (r) begin
            m_ack = 0; m_irq = 0; m_stop = 0; m_start = 0; m_en = 0;
        end else begin
            if (sset && d[2]) m_ack = 1; else if (sclr && d[2]) m_ack = 0;
            if (is) m_irq = 1; else if (ic || (sclr && d[3])) m_irq = 0;
            if (ss || (sset && d[4])) m_stop = 1; else if (sc) m_stop = 0;
            if (sset && d[5]) m_start = 1; else if (sclr && d[5]) m_start = 0;
            if (sset && d[6]) m_en = 1; else if (sclr && d[6]) m_en = 0;
        end
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = A_SET; bus_wr = 0; bus_wdata = 0;
        hw_irq_set = 0; hw_irq_clr = 0; hw_stop_set = 0; hw_stop_clr = 0;
        @(negedge clk);
        // R1 reset state
        step("R1 reset", 1, A_SET, 0, 32'h0, 0, 0, 0, 0);
        step("R1 reset hold", 1, A_SET, 1, 32'hFFFF_FFFF, 1, 0, 1, 0);
        step("R8 idle read", 0, A_SET, 0, 32'h0, 0, 0, 0, 0);
        // R2 set ack and enable only
        step("R2 set ack+en", 0, A_SET, 1, 32'h0000_0044, 0, 0, 0, 0);
        step("R2 zeros hold", 0, A_SET, 1, 32'h0000_0000, 0, 0, 0, 0);
        // R2/R5/R8 set everything incl. reserved and irq bit
        step("R5 set all", 0, A_SET, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R8 read set addr", 0, A_SET, 0, 32'h0, 0, 0, 0, 0);
        step("R8 read clr addr", 0, A_CLR, 0, 32'h0, 0, 0, 0, 0);
        // R3 clear ack
        step("R3 clear ack", 0, A_CLR, 1, 32'h0000_0004, 0, 0, 0, 0);
        // R4 clear-address bit 4 ignored
        step("R4 stop kept", 0, A_CLR, 1, 32'h0000_0010, 0, 0, 0, 0);
        step("R4 read back", 0, A_SET, 0, 32'h0, 0, 0, 0, 0);
        // R6 hardware strobes
        step("R6 hw stop clr", 0, A_SET, 0, 32'h0, 0, 0, 0, 1);
        step("R6 hw irq set", 0, A_SET, 0, 32'h0, 1, 0, 0, 0);
        step("R3 sw irq clr", 0, A_CLR, 1, 32'h0000_0008, 0, 0, 0, 0);
        step("R6 hw irq set2", 0, A_SET, 0, 32'h0, 1, 0, 0, 0);
        step("R6 hw irq clr", 0, A_SET, 0, 32'h0, 0, 1, 0, 0);
        step("R6 hw stop set", 0, A_SET, 0, 32'h0, 0, 0, 1, 0);
        // R7 priorities
        step("R7 hw set vs sw clr", 0, A_CLR, 1, 32'h0000_0008, 1, 0, 0, 0);
        step("R7 hw set vs hw clr irq", 0, A_SET, 0, 32'h0, 1, 1, 0, 0);
        step("R7 hw set vs hw clr stop", 0, A_SET, 0, 32'h0, 0, 0, 1, 1);
        // R9 other address ignored
        step("R9 other addr", 0, 8'h08, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R9 other addr clr", 0, 8'h04, 1, 32'h0000_007C, 0, 0, 0, 0);
        step("R9 read other", 0, 8'h08, 0, 32'h0, 0, 0, 0, 0);
        // R3 clear all, including interface disable at bit 6
        step("R3 clear all", 0, A_CLR, 1, 32'h0000_00FF, 0, 0, 0, 0);
        step("R3 read back", 0, A_SET, 0, 32'h0, 0, 0, 0, 0);
        // R1 mid-run reset
        step("R2 set start", 0, A_SET, 1, 32'h0000_0060, 0, 0, 1, 0);
        step("R1 mid reset", 1, A_SET, 0, 32'h0, 0, 0, 0, 0);
        step("R1 after reset", 0, A_SET, 0, 32'h0, 0, 0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule